// File: doc/BRIEF.md
# DDR SDRAM Mode Register Unit

This block is the device-side handler for mode programming inside a DDR SDRAM command decoder. On every rising clock edge it samples chip select, the three command strobes, clock enable, the bank address and the row address. When it sees a mode-programming command it checks that the command is legal. A legal command is routed by bank address bit 0 to either the base mode register or the extended mode register. The block then decodes the base register's burst length, burst type and read latency onto registered status outputs.

Each accepted write holds the unit busy for two clocks. The new register contents appear when the write completes. Any command that arrives inside that window is flagged and has no effect. Commands sent while some bank is open, or without clock enable held high, are also flagged and dropped. Reserved length or latency codes are still stored, but they raise a sticky flag. A request to reset the delay-locked loop is turned into a single-cycle pulse. Bank activity is reported by the surrounding controller through `banks_idle`.

Top module: `ddr_modereg_unit`

## Requirements
- R1: A mode-programming command is `cs_n`, `ras_n`, `cas_n` and `we_n` all sampled low on the same edge. `ba[0]`=0 targets the base register and `ba[0]`=1 targets the extended register. The extended register's stored value appears unchanged on `ext_mode`.
- R2: A command is accepted only if, on its edge, `banks_idle`=1 and `cke`=1, and `cke` was also 1 on the previous edge. Otherwise `err_precond` pulses high for one cycle after that edge, and no register, output or busy state changes.
- R3: On an accepted command, `busy` is high for the two cycles after the command edge. The write completes on the second edge after the command, and the new values are visible from then on. A command sampled on either of those two edges pulses `err_busy_cmd` for one cycle and is ignored. A command here is `cs_n` low with `ras_n`, `cas_n` and `we_n` not all high.
- R4: Base bits addr[2:0] set the burst length: 001 gives `burst_len`=2, 010 gives 4 and 011 gives 8. Every other code gives 0.
- R5: Base bit addr[3] drives `burst_interleave`: 0 is sequential and 1 is interleaved.
- R6: Base bits addr[6:4] set the read latency in half clocks on `cas_lat_half`: 010 gives 4, 110 gives 5 and 011 gives 6. Every other code gives 0.
- R7: Base bit addr[7] drives `test_mode`. Base bit addr[8]=1 makes `dll_reset_pulse` high for exactly the one cycle after the write completes. Extended writes never pulse it.
- R8: The decoded outputs and `ext_mode` keep their values until a later accepted write to the same register completes.
- R9: When a completed base write holds a reserved length or latency code, `reserved_code` goes high. It stays high until a base write with both codes legal completes. Extended writes leave it unchanged.
- R10: Synchronous active-high `rst` clears both registers, all decoded outputs and all flags, and drops `busy`. `programmed` is 0 after reset and becomes 1 when the first base write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank address, bit 0 selects the register |
| addr | input | ADDR_W | Row address carrying the register value |
| banks_idle | input | 1 | All banks idle, from the controller |
| busy | output | 1 | Write window in progress |
| burst_len | output | 4 | Decoded burst length, 0 when reserved |
| burst_interleave | output | 1 | Burst type, 1 means interleaved |
| cas_lat_half | output | 4 | Read latency in half clocks, 0 when reserved |
| test_mode | output | 1 | Test mode selected |
| dll_reset_pulse | output | 1 | One-cycle request to reset the DLL |
| ext_mode | output | ADDR_W | Stored extended register |
| programmed | output | 1 | Base register written since reset |
| err_precond | output | 1 | Command rejected on preconditions |
| err_busy_cmd | output | 1 | Command issued inside the write window |
| reserved_code | output | 1 | Sticky reserved-code flag |

## Verification
The bench uses the default widths: a 13-bit address, a 2-bit bank address and a two-cycle write window. With these, every field the decoder interprets is in reach, along with the bits above them. With the short window, a command can be placed on each edge of the busy period and on the first edge after it. That makes the window boundary, the back-to-back rejection and the single-cycle DLL pulse all observable within a few cycles.

// File: rtl/ddr_mr_pkg.sv
package ddr_mr_pkg;

  localparam int BL_LSB  = 0;
  localparam int BL_W    = 3;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int CL_W    = 3;
  localparam int TM_BIT  = 7;
  localparam int DLL_BIT = 8;
  localparam int OUT_W   = 4;

  function automatic logic [OUT_W-1:0] burst_len_of(input logic [BL_W-1:0] code);
    case (code)
      3'b001:  burst_len_of = OUT_W'(2);
      3'b010:  burst_len_of = OUT_W'(4);
      3'b011:  burst_len_of = OUT_W'(8);
      default: burst_len_of = '0;
    endcase
  endfunction

  function automatic logic [OUT_W-1:0] lat_half_of(input logic [CL_W-1:0] code);
    case (code)
      3'b010:  lat_half_of = OUT_W'(4);
      3'b110:  lat_half_of = OUT_W'(5);
      3'b011:  lat_half_of = OUT_W'(6);
      default: lat_half_of = '0;
    endcase
  endfunction

endpackage

// File: rtl/ddr_mr_cmd_check.sv
module ddr_mr_cmd_check (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic banks_idle,
  input  logic busy_i,
  output logic accept_o,
  output logic err_precond_o,
  output logic err_busy_o
);
  logic cke_q;
  logic any_cmd;
  logic is_mrs;
  logic ready;

  always_comb begin
    any_cmd  = !cs_n && !(ras_n && cas_n && we_n);
    is_mrs   = !cs_n && !ras_n && !cas_n && !we_n;
    ready    = banks_idle && cke && cke_q;
    accept_o = is_mrs && !busy_i && ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q         <= 1'b0;
      err_precond_o <= 1'b0;
      err_busy_o    <= 1'b0;
    end else begin
      cke_q         <= cke;
      err_precond_o <= is_mrs && !busy_i && !ready;
      err_busy_o    <= any_cmd && busy_i;
    end
  end

  p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    err_precond_o |-> !err_busy_o);

endmodule

// File: rtl/ddr_mr_write_seq.sv
module ddr_mr_write_seq #(
  parameter int ADDR_W    = 13,
  parameter int WR_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              tgt_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic              tgt_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    busy_o   = (cnt_q != '0);
    commit_o = (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tgt_o  <= 1'b0;
      addr_o <= '0;
    end else if (accept_i) begin
      cnt_q  <= CNT_W'(WR_CYCLES);
      tgt_o  <= tgt_i;
      addr_o <= addr_i;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
    accept_i |=> busy_o);

  p_no_accept_while_busy_r3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !accept_i);

  p_pending_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !accept_i) |=> $stable(addr_o) && $stable(tgt_o));

endmodule

// File: rtl/ddr_mr_regs.sv
module ddr_mr_regs
  import ddr_mr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NUM_MR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic              tgt_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OUT_W-1:0]  burst_len_o,
  output logic              interleave_o,
  output logic [OUT_W-1:0]  lat_half_o,
  output logic              test_mode_o,
  output logic              dll_pulse_o,
  output logic [ADDR_W-1:0] ext_o,
  output logic              programmed_o,
  output logic              reserved_o
);
  localparam int SEL_W = (NUM_MR > 1) ? $clog2(NUM_MR) : 1;

  logic [ADDR_W-1:0] mr_q [NUM_MR];
  logic [OUT_W-1:0]  new_bl;
  logic [OUT_W-1:0]  new_cl;
  logic              base_wr;
  logic [SEL_W-1:0]  sel;

  always_comb begin
    sel     = SEL_W'(tgt_i);
    base_wr = commit_i && (sel == '0);
    new_bl  = burst_len_of(addr_i[BL_LSB +: BL_W]);
    new_cl  = lat_half_of(addr_i[CL_LSB +: CL_W]);
    ext_o   = mr_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MR; i++) mr_q[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < NUM_MR; i++)
        if (sel == SEL_W'(i)) mr_q[i] <= addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_len_o  <= '0;
      interleave_o <= 1'b0;
      lat_half_o   <= '0;
      test_mode_o  <= 1'b0;
      dll_pulse_o  <= 1'b0;
      programmed_o <= 1'b0;
      reserved_o   <= 1'b0;
    end else begin
      dll_pulse_o <= base_wr && addr_i[DLL_BIT];
      if (base_wr) begin
        burst_len_o  <= new_bl;
        interleave_o <= addr_i[BT_BIT];
        lat_half_o   <= new_cl;
        test_mode_o  <= addr_i[TM_BIT];
        programmed_o <= 1'b1;
        reserved_o   <= (new_bl == '0) || (new_cl == '0);
      end
    end
  end

  p_dll_single_r7: assert property (@(posedge clk) disable iff (rst)
    dll_pulse_o |=> !dll_pulse_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(burst_len_o) && $stable(lat_half_o) && $stable(ext_o)
                  && $stable(test_mode_o) && $stable(interleave_o));

  p_bl_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (programmed_o && !reserved_o) |-> (burst_len_o inside {4'd2, 4'd4, 4'd8}));

  p_cl_legal_r6: assert property (@(posedge clk) disable iff (rst)
    (programmed_o && !reserved_o) |-> (lat_half_o inside {4'd4, 4'd5, 4'd6}));

endmodule

// File: rtl/ddr_modereg_unit.sv
module ddr_modereg_unit #(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int WR_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  output logic              busy,
  output logic [3:0]        burst_len,
  output logic              burst_interleave,
  output logic [3:0]        cas_lat_half,
  output logic              test_mode,
  output logic              dll_reset_pulse,
  output logic [ADDR_W-1:0] ext_mode,
  output logic              programmed,
  output logic              err_precond,
  output logic              err_busy_cmd,
  output logic              reserved_code
);
  logic              accept;
  logic              commit;
  logic              pend_tgt;
  logic [ADDR_W-1:0] pend_addr;

  ddr_mr_cmd_check u_check (
    .clk           (clk),
    .rst           (rst),
    .cs_n          (cs_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .we_n          (we_n),
    .cke           (cke),
    .banks_idle    (banks_idle),
    .busy_i        (busy),
    .accept_o      (accept),
    .err_precond_o (err_precond),
    .err_busy_o    (err_busy_cmd)
  );

  ddr_mr_write_seq #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .tgt_i    (ba[0]),
    .addr_i   (addr),
    .busy_o   (busy),
    .commit_o (commit),
    .tgt_o    (pend_tgt),
    .addr_o   (pend_addr)
  );

  ddr_mr_regs #(.ADDR_W(ADDR_W), .NUM_MR(2)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .commit_i     (commit),
    .tgt_i        (pend_tgt),
    .addr_i       (pend_addr),
    .burst_len_o  (burst_len),
    .interleave_o (burst_interleave),
    .lat_half_o   (cas_lat_half),
    .test_mode_o  (test_mode),
    .dll_pulse_o  (dll_reset_pulse),
    .ext_o        (ext_mode),
    .programmed_o (programmed),
    .reserved_o   (reserved_code)
  );

  p_reject_no_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (err_precond && !$past(busy)) |-> !busy);

endmodule

// File: tb/tb_ddr_modereg_unit.sv
module tb_ddr_modereg_unit;
  localparam int ADDR_W = 13;

  typedef enum int {K_BL, K_BT, K_CL, K_TM, K_DLL, K_EXT, K_PROG,
                    K_ERRP, K_VIOL, K_RSV, K_BUSY} kind_t;
  typedef struct {
    int    due;
    kind_t kind;
    int    val;
    string req;
  } exp_t;

  logic clk = 0, rst = 1;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, cke = 1, banks_idle = 1;
  logic [1:0] ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic busy, burst_interleave, test_mode, dll_reset_pulse, programmed;
  logic err_precond, err_busy_cmd, reserved_code;
  logic [3:0] burst_len, cas_lat_half;
  logic [ADDR_W-1:0] ext_mode;

  int cyc = 0, n_chk = 0, n_fail = 0, busy_last = -1;
  exp_t q[$];
  int m_rsv = 0;

  ddr_modereg_unit dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int get_out(kind_t k);
    case (k)
      K_BL:   return int'(burst_len);
      K_BT:   return int'(burst_interleave);
      K_CL:   return int'(cas_lat_half);
      K_TM:   return int'(test_mode);
      K_DLL:  return int'(dll_reset_pulse);
      K_EXT:  return int'(ext_mode);
      K_PROG: return int'(programmed);
      K_ERRP: return int'(err_precond);
      K_VIOL: return int'(err_busy_cmd);
      K_RSV:  return int'(reserved_code);
      default: return int'(busy);
    endcase
  endfunction

  function automatic int bl_model(int c);
    return (c == 1) ? 2 : (c == 2) ? 4 : (c == 3) ? 8 : 0;
  endfunction
  function automatic int cl_model(int c);
    return (c == 2) ? 4 : (c == 6) ? 5 : (c == 3) ? 6 : 0;
  endfunction

  task automatic push(int due, kind_t k, int v, string r);
    exp_t e;
    e.due = due; e.kind = k; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  // monitor: compares every expectation in the cycle it falls due
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        n_chk++;
        if (get_out(q[i].kind) !== q[i].val) begin
          n_fail++;
          $display("FAIL %s kind=%s cyc=%0d actual=%0d expected=%0d",
                   q[i].req, q[i].kind.name(), cyc, get_out(q[i].kind), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic nop(int n);
    repeat (n) begin
      @(negedge clk);
      cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; cke = 1; banks_idle = 1;
    end
  endtask

  // driver: issues one mode command and predicts its outcome
  task automatic mrs(logic [1:0] b, logic [ADDR_W-1:0] a, logic idle, logic ck);
    int s;
    logic prev;
    @(negedge clk);
    s = cyc + 1;
    prev = cke;
    cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0;
    ba = b; addr = a; banks_idle = idle; cke = ck;
    if (s <= busy_last) begin
      push(s, K_VIOL, 1, "R3");
    end else if (!(idle && ck && prev)) begin
      push(s, K_ERRP, 1, "R2");
      push(s, K_BUSY, 0, "R2");
      push(s + 2, K_BUSY, 0, "R2");
    end else begin
      busy_last = s + 2;
      push(s, K_ERRP, 0, "R2");
      push(s, K_VIOL, 0, "R3");
      push(s, K_BUSY, 1, "R3");
      push(s + 1, K_BUSY, 1, "R3");
      push(s + 2, K_BUSY, 0, "R3");
      if (b[0] == 1'b0) begin
        m_rsv = (bl_model(int'(a[2:0])) == 0 || cl_model(int'(a[6:4])) == 0) ? 1 : 0;
        push(s + 1, K_PROG, int'(programmed), "R10");
        push(s + 2, K_BL, bl_model(int'(a[2:0])), "R4");
        push(s + 2, K_BT, int'(a[3]), "R5");
        push(s + 2, K_CL, cl_model(int'(a[6:4])), "R6");
        push(s + 2, K_TM, int'(a[7]), "R7");
        push(s + 2, K_DLL, int'(a[8]), "R7");
        push(s + 3, K_DLL, 0, "R7");
        push(s + 2, K_PROG, 1, "R10");
      end else begin
        push(s + 2, K_EXT, int'(a), "R1");
        push(s + 2, K_DLL, 0, "R7");
      end
      push(s + 2, K_RSV, m_rsv, "R9");
    end
  endtask

  task automatic activate(logic idle);
    @(negedge clk);
    cs_n = 0; ras_n = 0; cas_n = 1; we_n = 1; banks_idle = idle; cke = 1;
    push(cyc + 1, K_VIOL, (cyc + 1 <= busy_last) ? 1 : 0, "R3");
  endtask

  // snapshot of the decoded state, checked one cycle later (R8 persistence)
  task automatic expect_hold(string r);
    push(cyc + 1, K_BL, int'(burst_len), r);
    push(cyc + 1, K_CL, int'(cas_lat_half), r);
    push(cyc + 1, K_EXT, int'(ext_mode), r);
    push(cyc + 1, K_TM, int'(test_mode), r);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    push(cyc + 1, K_PROG, 0, "R10");
    push(cyc + 1, K_BL, 0, "R10");
    push(cyc + 1, K_CL, 0, "R10");
    push(cyc + 1, K_EXT, 0, "R10");
    push(cyc + 1, K_RSV, 0, "R10");
    push(cyc + 1, K_BUSY, 0, "R10");
    nop(3);
    mrs(2'b00, 13'h022, 1, 1); nop(4);          // BL4 seq CL2
    mrs(2'b00, 13'h1EB, 1, 1); nop(4);          // BL8 interleaved CL2.5 test DLL
    mrs(2'b00, 13'h031, 1, 1); nop(4);          // BL2 CL3
    mrs(2'b01, 13'h1A5, 1, 1); nop(4);          // extended write, R1
    expect_hold("R8"); nop(2);
    mrs(2'b00, 13'h024, 1, 1); nop(4);          // reserved BL, R9
    mrs(2'b01, 13'h003, 1, 1); nop(4);          // extended leaves flag, R9
    mrs(2'b00, 13'h052, 1, 1); nop(4);          // reserved CL, R9
    mrs(2'b00, 13'h032, 1, 1); nop(4);          // valid clears flag, R9
    // R2: banks not idle
    expect_hold("R2");
    mrs(2'b00, 13'h1EB, 0, 1); nop(1);
    expect_hold("R2"); nop(3);
    // R2: CKE low on previous edge
    @(negedge clk); cke = 0;
    mrs(2'b00, 13'h1EB, 1, 1); nop(1);
    expect_hold("R2"); nop(3);
    // R2: CKE low on command edge
    mrs(2'b00, 13'h1EB, 1, 0); nop(4);
    // R3: back-to-back commands inside the window
    mrs(2'b00, 13'h061, 1, 1);
    mrs(2'b00, 13'h1EB, 1, 1);
    activate(1);
    mrs(2'b01, 13'h0FF, 1, 1);                  // first edge after window: accepted
    nop(5);
    expect_hold("R8"); nop(2);
    // R3: command inside window with banks open still only a violation
    mrs(2'b00, 13'h022, 1, 1);
    activate(0);
    nop(6);
    // R10: reset mid-stream clears everything
    mrs(2'b00, 13'h1EB, 1, 1); nop(4);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; busy_last = -1; m_rsv = 0;
    push(cyc, K_PROG, 0, "R10");
    push(cyc, K_BL, 0, "R10");
    push(cyc, K_TM, 0, "R10");
    push(cyc, K_EXT, 0, "R10");
    nop(4);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R3 pending=%0d expected=0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule